// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns the operand fields of one memory reference into a linear address. It picks the segment that the reference uses and forms the offset as base plus scaled index plus sign-extended displacement. It then applies the segment's cached base according to the current operating mode. In 32-bit legacy and compatibility operation the offset is compared with the segment limit. In 64-bit operation the result is instead tested for canonical form.

The unit is a single pipeline stage. The operand fields, the six cached segment bases and limits, and the mode are presented together with `in_valid`. One clock later the chosen segment, the linear address and the fault flag appear together, qualified by `out_valid`. While no request is presented, the last result is held.

Segment codes: ES=0, CS=1, SS=2, DS=3, FS=4, GS=5. Mode codes: 0 legacy, 1 compatibility, 2 64-bit, 3 treated as legacy. Scale codes: 0→×1, 1→×2, 2→×4, 3→×8. The cached bases and limits are packed with segment code k in slice k.

Top module: `seg_ea_gen`

## Requirements
- R1: The segment is chosen in this priority order. A string destination (`str_dst`=1) uses ES (code 0). Otherwise an override (`seg_ovr_en`=1) uses `seg_ovr`. Otherwise a stack access uses SS (code 2). Otherwise the reference uses DS (code 3).
- R2: An override code of 6 or 7 selects DS (code 3).
- R3: The offset is `base_val + (index_val << scale_sel) + sign-extended disp`, taken modulo 2^64.
- R4: In modes 0, 1 and 3, `lin_addr[31:0]` = (segment base[31:0] + offset[31:0]) mod 2^32, and `lin_addr[63:32]` = 0.
- R5: In modes 0, 1 and 3, `fault` is 1 exactly when offset[31:0] is greater than the selected 32-bit limit. An offset equal to the limit does not fault.
- R6: In mode 2, the CS, DS, ES and SS references use base 0, and their limits are ignored.
- R7: In mode 2, an FS or GS reference adds the full 64-bit base, and the sum wraps modulo 2^64.
- R8: In mode 2, `fault` is 1 exactly when bits 63 down to 47 of `lin_addr` are not all equal.
- R9: In compatibility mode, bits 63:32 of the FS and GS bases have no effect on the result.
- R10: The results appear one cycle after `in_valid`, with `out_valid`=1. On a cycle without `in_valid`, `out_valid` is 0 on the next cycle and `out_seg`, `lin_addr` and `fault` hold their values.
- R11: During reset, `out_valid`, `out_seg`, `lin_addr` and `fault` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| mode | input | 2 | Operating mode code |
| seg_ovr_en | input | 1 | Explicit segment override present |
| seg_ovr | input | 3 | Override segment code |
| str_dst | input | 1 | Reference is a string destination |
| stack_op | input | 1 | Reference is a stack access |
| base_val | input | 64 | Base register value |
| index_val | input | 64 | Index register value |
| scale_sel | input | 2 | Index scale code |
| disp | input | 32 | Signed displacement |
| seg_base_all | input | 384 | Six cached segment bases, 64 bits each |
| seg_limit_all | input | 192 | Six cached segment limits, 32 bits each |
| out_valid | output | 1 | Result valid |
| out_seg | output | 3 | Segment used |
| lin_addr | output | 64 | Linear address |
| fault | output | 1 | Limit or canonical fault |

## Verification
The assertions take for granted that `rst_n` is synchronous and that the mode and the request fields are steady across the clock edge at which `in_valid` is sampled. They also take for granted that the canonical width is at least 32 bits, so that a legacy result, whose upper half is zero, is never compared against a canonical pattern. The stimulus keeps within these assumptions by changing every input only on the falling clock edge. It uses only mode codes 0 to 3 and keeps the canonical width at its default.

// File: rtl/seg_ea_pkg.sv
package seg_ea_pkg;
    typedef enum logic [2:0] {
        SEG_ES = 3'd0,
        SEG_CS = 3'd1,
        SEG_SS = 3'd2,
        SEG_DS = 3'd3,
        SEG_FS = 3'd4,
        SEG_GS = 3'd5
    } seg_e;

    typedef enum logic [1:0] {
        MODE_LEG  = 2'd0,
        MODE_CMP  = 2'd1,
        MODE_LONG = 2'd2,
        MODE_RSV  = 2'd3
    } mode_e;

    localparam int NUM_SEG = 6;
endpackage

// File: rtl/seg_ea_seg_select.sv
module seg_ea_seg_select
    import seg_ea_pkg::*;
(
    input  logic       ovr_en,
    input  logic [2:0] ovr_code,
    input  logic       str_dst,
    input  logic       stack_op,
    output seg_e       seg
);
    seg_e ovr_seg;

    // Override codes outside the six defined segments fall back to DS (R2)
    always_comb begin
        unique case (ovr_code)
            3'd0:    ovr_seg = SEG_ES;
            3'd1:    ovr_seg = SEG_CS;
            3'd2:    ovr_seg = SEG_SS;
            3'd3:    ovr_seg = SEG_DS;
            3'd4:    ovr_seg = SEG_FS;
            3'd5:    ovr_seg = SEG_GS;
            default: ovr_seg = SEG_DS;
        endcase
    end

    // Priority order of R1: string destination, override, stack, default
    always_comb begin
        if (str_dst)       seg = SEG_ES;
        else if (ovr_en)   seg = ovr_seg;
        else if (stack_op) seg = SEG_SS;
        else               seg = SEG_DS;
    end
endmodule

// File: rtl/seg_ea_offset.sv
module seg_ea_offset #(
    parameter int AW = 64,
    parameter int DW = 32
) (
    input  logic [AW-1:0] base_val,
    input  logic [AW-1:0] index_val,
    input  logic [1:0]    scale_sel,
    input  logic [DW-1:0] disp,
    output logic [AW-1:0] offset
);
    localparam int EXT = AW - DW;

    logic [AW-1:0] scaled;
    logic [AW-1:0] disp_ext;

    always_comb begin
        unique case (scale_sel)
            2'd0: scaled = index_val;
            2'd1: scaled = {index_val[AW-2:0], 1'b0};
            2'd2: scaled = {index_val[AW-3:0], 2'b00};
            2'd3: scaled = {index_val[AW-4:0], 3'b000};
        endcase
    end

    generate
        if (EXT > 0) begin : g_sext
            assign disp_ext = {{EXT{disp[DW-1]}}, disp};
        end else begin : g_nosext
            assign disp_ext = disp[AW-1:0];
        end
    endgenerate

    // R3: modulo-2^AW three-operand sum
    assign offset = base_val + scaled + disp_ext;
endmodule

// File: rtl/seg_ea_addr_check.sv
module seg_ea_addr_check
    import seg_ea_pkg::*;
#(
    parameter int AW      = 64,
    parameter int LW      = 32,
    parameter int VA_BITS = 48
) (
    input  mode_e         mode,
    input  seg_e          seg,
    input  logic [AW-1:0] seg_base,
    input  logic [LW-1:0] seg_limit,
    input  logic [AW-1:0] offset,
    output logic [AW-1:0] lin_addr,
    output logic          fault
);
    localparam int TOPW = AW - VA_BITS + 1;

    logic [AW-1:0] long_base;
    logic [AW-1:0] long_sum;
    logic [LW-1:0] leg_off;
    logic [LW-1:0] leg_sum;
    logic          canon_ok;

    // R6/R7: only FS and GS keep a base in 64-bit mode
    assign long_base = (seg == SEG_FS || seg == SEG_GS) ? seg_base : '0;
    assign long_sum  = long_base + offset;
    assign leg_off   = offset[LW-1:0];
    assign leg_sum   = seg_base[LW-1:0] + leg_off;

    generate
        if (TOPW > 1) begin : g_canon
            logic [TOPW-1:0] top;
            assign top      = long_sum[AW-1:VA_BITS-1];
            assign canon_ok = (&top) | ~(|top);
        end else begin : g_flat
            assign canon_ok = 1'b1;
        end
    endgenerate

    always_comb begin
        unique case (mode)
            MODE_LONG: begin
                lin_addr = long_sum;
                fault    = ~canon_ok;
            end
            default: begin
                lin_addr = {{(AW-LW){1'b0}}, leg_sum};
                fault    = leg_off > seg_limit;
            end
        endcase
    end
endmodule

// File: rtl/seg_ea_gen.sv
module seg_ea_gen
    import seg_ea_pkg::*;
#(
    parameter int AW      = 64,
    parameter int LW      = 32,
    parameter int DW      = 32,
    parameter int VA_BITS = 48
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [1:0]           mode,
    input  logic                 seg_ovr_en,
    input  logic [2:0]           seg_ovr,
    input  logic                 str_dst,
    input  logic                 stack_op,
    input  logic [AW-1:0]        base_val,
    input  logic [AW-1:0]        index_val,
    input  logic [1:0]           scale_sel,
    input  logic [DW-1:0]        disp,
    input  logic [6*AW-1:0]      seg_base_all,
    input  logic [6*LW-1:0]      seg_limit_all,
    output logic                 out_valid,
    output logic [2:0]           out_seg,
    output logic [AW-1:0]        lin_addr,
    output logic                 fault
);
    logic [AW-1:0] bases  [NUM_SEG];
    logic [LW-1:0] limits [NUM_SEG];

    genvar k;
    generate
        for (k = 0; k < NUM_SEG; k++) begin : g_unpack
            assign bases[k]  = seg_base_all[k*AW +: AW];
            assign limits[k] = seg_limit_all[k*LW +: LW];
        end
    endgenerate

    seg_e          sel_seg;
    mode_e         cur_mode;
    logic [AW-1:0] offset;
    logic [AW-1:0] sel_base;
    logic [LW-1:0] sel_limit;
    logic [AW-1:0] nxt_addr;
    logic          nxt_fault;

    assign cur_mode = mode_e'(mode);

    seg_ea_seg_select u_sel (
        .ovr_en   (seg_ovr_en),
        .ovr_code (seg_ovr),
        .str_dst  (str_dst),
        .stack_op (stack_op),
        .seg      (sel_seg)
    );

    seg_ea_offset #(.AW(AW), .DW(DW)) u_off (
        .base_val  (base_val),
        .index_val (index_val),
        .scale_sel (scale_sel),
        .disp      (disp),
        .offset    (offset)
    );

    always_comb begin
        unique case (sel_seg)
            SEG_ES:  begin sel_base = bases[0]; sel_limit = limits[0]; end
            SEG_CS:  begin sel_base = bases[1]; sel_limit = limits[1]; end
            SEG_SS:  begin sel_base = bases[2]; sel_limit = limits[2]; end
            SEG_DS:  begin sel_base = bases[3]; sel_limit = limits[3]; end
            SEG_FS:  begin sel_base = bases[4]; sel_limit = limits[4]; end
            default: begin sel_base = bases[5]; sel_limit = limits[5]; end
        endcase
    end

    seg_ea_addr_check #(.AW(AW), .LW(LW), .VA_BITS(VA_BITS)) u_chk (
        .mode      (cur_mode),
        .seg       (sel_seg),
        .seg_base  (sel_base),
        .seg_limit (sel_limit),
        .offset    (offset),
        .lin_addr  (nxt_addr),
        .fault     (nxt_fault)
    );

    // Address and fault leave through the same register stage (R10, R11)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_seg   <= 3'd0;
            lin_addr  <= '0;
            fault     <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_seg  <= sel_seg;
                lin_addr <= nxt_addr;
                fault    <= nxt_fault;
            end
        end
    end
endmodule

// File: rtl/seg_ea_checker.sv
module seg_ea_checker #(
    parameter int AW      = 64,
    parameter int VA_BITS = 48
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [1:0]    mode,
    input logic          seg_ovr_en,
    input logic          str_dst,
    input logic          stack_op,
    input logic          out_valid,
    input logic [2:0]    out_seg,
    input logic [AW-1:0] lin_addr,
    input logic          fault
);
    p_valid_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(lin_addr) && $stable(fault) && $stable(out_seg)));
    p_str_es_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && str_dst) |=> (out_seg == 3'd0));
    p_stack_ss_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !str_dst && !seg_ovr_en && stack_op) |=> (out_seg == 3'd2));
    p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode != 2'd2) |=> (lin_addr[AW-1:32] == '0));
    p_canon_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'd2) |=>
        (fault == !((&lin_addr[AW-1:VA_BITS-1]) || !(|lin_addr[AW-1:VA_BITS-1]))));
endmodule

bind seg_ea_gen seg_ea_checker #(.AW(AW), .VA_BITS(VA_BITS)) u_seg_ea_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .mode       (mode),
    .seg_ovr_en (seg_ovr_en),
    .str_dst    (str_dst),
    .stack_op   (stack_op),
    .out_valid  (out_valid),
    .out_seg    (out_seg),
    .lin_addr   (lin_addr),
    .fault      (fault)
);

// File: tb/seg_ea_gen_test.sv
`timescale 1ns/1ps
module seg_ea_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        seg_ovr_en = 1'b0;
    logic [2:0]  seg_ovr = 3'd0;
    logic        str_dst = 1'b0;
    logic        stack_op = 1'b0;
    logic [63:0] base_val = '0;
    logic [63:0] index_val = '0;
    logic [1:0]  scale_sel = 2'd0;
    logic [31:0] disp = '0;
    logic [383:0] seg_base_all;
    logic [191:0] seg_limit_all;
    logic        out_valid;
    logic [2:0]  out_seg;
    logic [63:0] lin_addr;
    logic        fault;

    logic [63:0] sb  [6];
    logic [31:0] lim [6];

    always_comb begin
        for (int i = 0; i < 6; i++) begin
            seg_base_all[i*64 +: 64]  = sb[i];
            seg_limit_all[i*32 +: 32] = lim[i];
        end
    end

    always #2.5 clk = ~clk;

    seg_ea_gen uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .seg_ovr_en(seg_ovr_en), .seg_ovr(seg_ovr), .str_dst(str_dst),
        .stack_op(stack_op), .base_val(base_val), .index_val(index_val),
        .scale_sel(scale_sel), .disp(disp), .seg_base_all(seg_base_all),
        .seg_limit_all(seg_limit_all), .out_valid(out_valid), .out_seg(out_seg),
        .lin_addr(lin_addr), .fault(fault)
    );

    typedef struct {
        logic [2:0]  seg;
        logic [63:0] addr;
        logic        flt;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [63:0] last_addr = '0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Independent reference model written from the requirements
    function automatic exp_t model(input logic [1:0] md, input logic oen, input logic [2:0] oc,
                                   input logic sd, input logic st, input logic [63:0] b,
                                   input logic [63:0] x, input logic [1:0] sc, input logic [31:0] d,
                                   input string tag);
        exp_t e;
        logic [63:0] off;
        logic [63:0] segb;
        logic [31:0] o32;
        logic [16:0] hi;
        if (sd) e.seg = 3'd0;
        else if (oen) e.seg = (oc > 3'd5) ? 3'd3 : oc;
        else if (st) e.seg = 3'd2;
        else e.seg = 3'd3;
        off = b + x * (64'd1 << sc) + 64'($signed(d));
        if (md == 2'd2) begin
            segb = (e.seg == 3'd4 || e.seg == 3'd5) ? sb[e.seg] : 64'd0;
            e.addr = segb + off;
            hi = e.addr[63:47];
            e.flt = !(hi == 17'h0 || hi == 17'h1ffff);
        end else begin
            o32 = off[31:0];
            e.addr = {32'd0, sb[e.seg][31:0] + o32};
            e.flt = o32 > lim[e.seg];
        end
        e.tag = tag;
        return e;
    endfunction

    task automatic drive(input logic [1:0] md, input logic oen, input logic [2:0] oc,
                         input logic sd, input logic st, input logic [63:0] b,
                         input logic [63:0] x, input logic [1:0] sc, input logic [31:0] d,
                         input string tag);
        exp_t e;
        @(negedge clk);
        mode = md; seg_ovr_en = oen; seg_ovr = oc; str_dst = sd; stack_op = st;
        base_val = b; index_val = x; scale_sel = sc; disp = d; in_valid = 1'b1;
        e = model(md, oen, oc, sd, st, b, x, sc, d, tag);
        last_addr = e.addr;
        exp_q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        base_val = 64'hdead_beef_0000_1111;
    endtask

    // Monitor: pop and compare each result as it appears
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected result", {61'd0, out_seg}, 64'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(out_seg == e.seg, {e.tag, " seg"}, {61'd0, out_seg}, {61'd0, e.seg});
                check(lin_addr == e.addr, {e.tag, " addr"}, lin_addr, e.addr);
                check(fault == e.flt, {e.tag, " fault"}, {63'd0, fault}, {63'd0, e.flt});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        sb[0] = 64'h0000_0000_0000_1000; lim[0] = 32'h0000_ffff;
        sb[1] = 64'h0000_0000_0040_0000; lim[1] = 32'hffff_ffff;
        sb[2] = 64'h0000_0000_0002_0000; lim[2] = 32'h0000_0fff;
        sb[3] = 64'h0000_0000_0010_0000; lim[3] = 32'h000f_ffff;
        sb[4] = 64'h1234_5678_0000_8000; lim[4] = 32'h0001_0000;
        sb[5] = 64'hffff_8000_0000_0000; lim[5] = 32'hffff_ffff;
        repeat (3) @(negedge clk);
        // R11 reset state
        check(out_valid == 0 && out_seg == 0 && lin_addr == 0 && fault == 0,
              "R11 reset", lin_addr, 64'd0);
        rst_n = 1'b1;
        // R1 selection and priority
        drive(2'd0, 0, 3'd0, 0, 0, 64'h100, 64'h10, 2'd2, 32'h4, "R1 default DS");
        drive(2'd0, 0, 3'd0, 0, 1, 64'h200, 64'h0, 2'd0, 32'h8, "R1 stack SS");
        drive(2'd0, 1, 3'd4, 1, 0, 64'h10, 64'h1, 2'd0, 32'h0, "R1 strdst beats override");
        drive(2'd0, 1, 3'd5, 0, 1, 64'h10, 64'h3, 2'd3, 32'h0, "R1 override beats stack");
        drive(2'd0, 1, 3'd1, 0, 0, 64'h20, 64'h2, 2'd1, 32'h0, "R1 override CS");
        // R2 undefined override codes
        drive(2'd0, 1, 3'd6, 0, 0, 64'h30, 64'h0, 2'd0, 32'h0, "R2 code6 DS");
        drive(2'd3, 1, 3'd7, 0, 0, 64'h30, 64'h0, 2'd0, 32'h0, "R2 code7 DS mode3");
        // R3 scales and negative displacement
        drive(2'd0, 0, 3'd0, 0, 0, 64'h1000, 64'h7, 2'd0, 32'hffff_fff0, "R3 scale1 negdisp");
        drive(2'd0, 0, 3'd0, 0, 0, 64'h1000, 64'h7, 2'd1, 32'h0, "R3 scale2");
        drive(2'd0, 0, 3'd0, 0, 0, 64'h1000, 64'h7, 2'd3, 32'h0, "R3 scale8");
        // R5 limit boundary on SS (limit 0xfff)
        drive(2'd0, 0, 3'd0, 0, 1, 64'hfff, 64'h0, 2'd0, 32'h0, "R5 at limit");
        drive(2'd1, 0, 3'd0, 0, 1, 64'h1000, 64'h0, 2'd0, 32'h0, "R5 above limit");
        // R4 32-bit wrap of base plus offset
        drive(2'd0, 1, 3'd1, 0, 0, 64'hffd0_0000, 64'h0, 2'd0, 32'h0, "R4 wrap 32");
        drive(2'd0, 0, 3'd0, 0, 0, 64'hffff_ffff_0000_0010, 64'h0, 2'd0, 32'h0, "R4 offset truncated");
        // R9 compatibility ignores FS/GS upper base
        drive(2'd1, 1, 3'd4, 0, 0, 64'h40, 64'h0, 2'd0, 32'h0, "R9 compat FS");
        drive(2'd1, 1, 3'd5, 0, 0, 64'h40, 64'h0, 2'd0, 32'h0, "R9 compat GS");
        // R6 64-bit base 0 and no limit
        drive(2'd2, 0, 3'd0, 0, 0, 64'h7fff_0000_0000, 64'h0, 2'd0, 32'h0, "R6 DS base0 nolimit");
        drive(2'd2, 0, 3'd0, 0, 1, 64'h5000, 64'h0, 2'd0, 32'h0, "R6 SS base0");
        drive(2'd2, 1, 3'd1, 1, 0, 64'h5000, 64'h0, 2'd0, 32'h0, "R6 ES base0");
        // R7 FS/GS full base and wrap
        drive(2'd2, 1, 3'd4, 0, 0, 64'h100, 64'h0, 2'd0, 32'h0, "R7 FS full base");
        drive(2'd2, 1, 3'd5, 0, 0, 64'h0000_8000_0000_0010, 64'h0, 2'd0, 32'h0, "R7 GS wrap 2^64");
        // R8 canonical boundaries
        drive(2'd2, 0, 3'd0, 0, 0, 64'h0000_7fff_ffff_ffff, 64'h0, 2'd0, 32'h0, "R8 top canonical");
        drive(2'd2, 0, 3'd0, 0, 0, 64'h0000_8000_0000_0000, 64'h0, 2'd0, 32'h0, "R8 noncanonical");
        drive(2'd2, 0, 3'd0, 0, 0, 64'h0, 64'h0, 2'd0, 32'hffff_ffff, "R8 negative canonical");
        // R10 hold while idle
        idle();
        idle();
        idle();
        check(out_valid == 1'b0, "R10 valid low when idle", {63'd0, out_valid}, 64'd0);
        check(lin_addr == last_addr, "R10 hold address", lin_addr, last_addr);
        check(exp_q.size() == 0, "R10 all results seen", 64'(exp_q.size()), 64'd0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule